// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single read or write requests into bus cycles on a pin set where the low address bits and the data share the same lines. A request carries an address, a memory-or-I/O select and, for writes, a data word. The sequencer then steps through four clock-wide bus states, T1 to T4. In T1 it places the low address on the shared lines and pulses the address strobe. An external latch captures the address on that pulse. The sequencer then frees the lines for data, asserts the read or write strobe and enables the data transceiver.

A slow device holds the `ready` input low to stretch the cycle with wait states between T3 and T4. Read data is taken from the shared lines when the cycle is allowed to finish and is returned on a response channel. The shared lines are modelled as three separate signals: a driven value, an output enable and a sampled input. The latch sits inside the block so that its output can be observed at the ports.

Both the request and the response use valid/ready handshakes. A request is accepted only while `req_ready` is high, and that happens only when no cycle is in flight. A read response stays on `rsp_valid`/`rsp_rdata` until `rsp_ready` is seen high. No new request is accepted until then. Writes produce no response.

Top module: `mux_bus_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and T1 follows in the next cycle. Request inputs are not looked at again during that cycle.
- R2: `ale` is high in T1 only. During T1, `ad_out` carries the low DW address bits and `ad_oe` is 1. Throughout T1..T4, `a_hi` carries the upper address bits.
- R3: `lat_addr` takes the bus value on the clock edge that ends a cycle with `ale` high. It holds that value unchanged while `ale` is low, so from T2 on it equals the low address of the current request.
- R4: `mio` is 1 for a memory cycle (`req_mem`=1) and 0 for an I/O cycle. It stays unchanged from T1 until the next request is accepted.
- R5: In a read, `rd_n` is 0 in T2, T3 and every wait state, and 1 otherwise. `ad_oe` is 0 from T2 through T4, and `dtr` is 0 (receive).
- R6: In a write, `dtr` is 1 (transmit) from T1 through T4. `ad_out` carries the write data with `ad_oe`=1 from T2 through T4. `wr_n` is 0 in T2, T3 and every wait state.
- R7: `ready` is sampled only on the edge that ends T3 or a wait state. Each low sample adds one wait state, and a high sample moves to T4. The value of `ready` in T1, T2 and T4 has no effect.
- R8: A read captures `ad_in` on the edge that ends the last T3 or wait state. The next cycle after T4 shows `rsp_valid`=1 with that value on `rsp_rdata`, held stable until `rsp_ready` is high. A write ends in idle with `rsp_valid`=0.
- R9: `rd_n` and `wr_n` are never both 0. `den_n` is 0 exactly while one of them is 0, and 1 in idle, T1 and T4. In idle, `ad_oe`=0, `ale`=0 and `dtr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | AW | Full address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DW | Read data |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| mio | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Active-low transceiver enable |
| ready | input | 1 | Device ready, low requests wait states |
| ad_out | output | DW | Value driven on the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | DW | Value sampled from the shared lines |
| a_hi | output | AW-DW | Upper address bits |
| lat_addr | output | DW | Output of the address latch |

## Verification
The hardest point to reach is the read-data capture edge inside a run of wait states. A design that samples one cycle early or late returns a plausible value unless the lines carry something different in the neighbouring cycles. The bench therefore drives the true read word on `ad_in` only in the final T3 or wait-state cycle. In every other cycle, T2 and T4 included, it drives the complement or random data. It also randomises `ready` in T1, T2 and T4, so that a sequencer sampling `ready` in the wrong state loses or gains a wait state and fails the per-cycle pin checks.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5,
    PH_RSP  = 3'd6
  } phase_e;
endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_mem,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  input  logic          rsp_ready,
  output phase_e        phase,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          cur_write,
  output logic          cur_mem,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_wdata
);
  logic sample_pt;

  // ready matters only on the edge that closes T3 or a wait state
  assign sample_pt = (phase == PH_T3) || (phase == PH_TW);
  assign req_ready = (phase == PH_IDLE);
  assign rsp_valid = (phase == PH_RSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cur_write <= 1'b0;
      cur_mem   <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rsp_rdata <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          cur_write <= req_write;
          cur_mem   <= req_mem;
          cur_addr  <= req_addr;
          cur_wdata <= req_wdata;
          phase     <= PH_T1;
        end
        PH_T1:   phase <= PH_T2;
        PH_T2:   phase <= PH_T3;
        PH_T3, PH_TW: begin
          if (sample_pt && ready) begin
            if (!cur_write) rsp_rdata <= ad_in;
            phase <= PH_T4;
          end else begin
            phase <= PH_TW;
          end
        end
        PH_T4:   phase <= cur_write ? PH_IDLE : PH_RSP;
        PH_RSP:  if (rsp_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  phase_e           phase,
  input  logic             cur_write,
  input  logic             cur_mem,
  input  logic [AW-1:0]    cur_addr,
  input  logic [DW-1:0]    cur_wdata,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             den_n,
  output logic             dtr,
  output logic             mio,
  output logic             ad_oe,
  output logic [DW-1:0]    ad_out,
  output logic [AW-DW-1:0] a_hi
);
  logic strobe;
  logic busy;

  always_comb begin
    strobe = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
    busy   = (phase == PH_T1) || strobe || (phase == PH_T4);
    ale    = (phase == PH_T1);
    rd_n   = !(strobe && !cur_write);
    wr_n   = !(strobe && cur_write);
    den_n  = !strobe;
    dtr    = busy && cur_write;
    mio    = cur_mem;
    ad_oe  = (phase == PH_T1) || (busy && cur_write);
    ad_out = (phase == PH_T1) ? cur_addr[DW-1:0] : cur_wdata;
    a_hi   = cur_addr[AW-1:DW];
  end
endmodule

// File: rtl/mbs_addr_latch.sv
module mbs_addr_latch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [DW-1:0] bus,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (ale) q <= bus;
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_mem,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             mio,
  output logic             dtr,
  output logic             den_n,
  input  logic             ready,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0]    lat_addr
);
  phase_e        phase;
  logic          cur_write;
  logic          cur_mem;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic [DW-1:0] bus_view;

  mbs_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_mem(req_mem),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .ad_in(ad_in), .rsp_ready(rsp_ready),
    .phase(phase), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .cur_write(cur_write), .cur_mem(cur_mem),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  mbs_pins #(.AW(AW), .DW(DW)) u_pins (
    .phase(phase), .cur_write(cur_write), .cur_mem(cur_mem),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dtr(dtr),
    .mio(mio), .ad_oe(ad_oe), .ad_out(ad_out), .a_hi(a_hi)
  );

  // what an observer on the shared lines would see
  assign bus_view = ad_oe ? ad_out : ad_in;

  mbs_addr_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .bus(bus_view), .q(lat_addr)
  );
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          ready,
  input logic          ale,
  input logic          rd_n,
  input logic          wr_n,
  input logic          den_n,
  input logic          dtr,
  input logic          mio,
  input logic          ad_oe,
  input logic [DW-1:0] lat_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata
);
  AST_ACCEPT_T1: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> ale); // R1
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ale |=> $stable(lat_addr)); // R3
  AST_MIO_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n || !wr_n) |-> $stable(mio)); // R4
  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe); // R5
  AST_DEN_DIR: assert property (@(posedge clk) disable iff (!rst_n) !den_n |-> (dtr == !wr_n)); // R6
  AST_WAIT_RD: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n && !ready) |=> !rd_n); // R7
  AST_WAIT_WR: assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && !ready) |=> !wr_n); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) (rd_n || wr_n)); // R9
endmodule

bind mux_bus_seq mux_bus_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ready(ready), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
  .dtr(dtr), .mio(mio), .ad_oe(ad_oe), .lat_addr(lat_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
);

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             req_valid = 0, req_write = 0, req_mem = 0;
  logic [AW-1:0]    req_addr = '0;
  logic [DW-1:0]    req_wdata = '0;
  logic             rsp_ready = 0, ready = 0;
  logic [DW-1:0]    ad_in = '0;
  logic             req_ready, rsp_valid, ale, rd_n, wr_n, mio, dtr, den_n, ad_oe;
  logic [DW-1:0]    rsp_rdata, ad_out, lat_addr;
  logic [AW-DW-1:0] a_hi;

  int  errs = 0;
  int  checks = 0;
  bit  done = 0;

  mux_bus_seq #(.AW(AW), .DW(DW)) u_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mem(req_mem), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .mio(mio),
    .dtr(dtr), .den_n(den_n), .ready(ready), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .a_hi(a_hi), .lat_addr(lat_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_pins();
    chk(req_ready == 1'b1, "R1 idle req_ready", req_ready, 1);
    chk(ale == 1'b0 && ad_oe == 1'b0 && dtr == 1'b0, "R9 idle ale/oe/dtr", {ale, ad_oe, dtr}, 0);
    chk(rd_n && wr_n && den_n, "R9 idle strobes", {rd_n, wr_n, den_n}, 3'b111);
    chk(rsp_valid == 1'b0, "R8 idle rsp_valid", rsp_valid, 0);
  endtask

  // ph: 1 = T1, 2 = T2/T3/wait, 4 = T4
  task automatic bus_pins(input int ph, input bit w, input bit m,
                          input logic [AW-1:0] a, input logic [DW-1:0] wd);
    bit e_ale, strobe, e_oe;
    e_ale  = (ph == 1);
    strobe = (ph == 2);
    e_oe   = (ph == 1) || w;
    chk(req_ready == 1'b0, "R1 busy req_ready", req_ready, 0);
    chk(ale == e_ale, "R2 ale", ale, e_ale);
    chk(a_hi == a[AW-1:DW], "R2 a_hi", a_hi, a[AW-1:DW]);
    chk(mio == m, "R4 mio", mio, m);
    chk(rd_n == !(strobe && !w), "R5 rd_n", rd_n, !(strobe && !w));
    chk(ad_oe == e_oe, "R5 ad_oe", ad_oe, e_oe);
    chk(dtr == w, "R6 dtr", dtr, w);
    chk(wr_n == !(strobe && w), "R6 wr_n", wr_n, !(strobe && w));
    chk(den_n == !strobe, "R9 den_n", den_n, !strobe);
    if (ph == 1) chk(ad_out == a[DW-1:0], "R2 ad_out address", ad_out, a[DW-1:0]);
    else if (w)  chk(ad_out == wd, "R6 ad_out wdata", ad_out, wd);
    if (ph != 1) chk(lat_addr == a[DW-1:0], "R3 lat_addr", lat_addr, a[DW-1:0]);
  endtask

  // called at a negedge while idle; returns at a negedge while idle
  task automatic run(input bit w, input bit m, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                     input int waits, input int bp);
    idle_pins();
    req_valid = 1; req_write = w; req_mem = m; req_addr = a; req_wdata = wd;
    @(negedge clk);                                  // T1
    req_valid = 0; req_write = $urandom; req_mem = $urandom;
    req_addr = AW'($urandom); req_wdata = DW'($urandom);
    bus_pins(1, w, m, a, wd);
    ready = $urandom;                                // R7 ignored in T1
    ad_in = ~rd;
    @(negedge clk);                                  // T2
    bus_pins(2, w, m, a, wd);
    ready = $urandom;                                // R7 ignored in T2
    ad_in = ~rd;
    @(negedge clk);                                  // T3, then waits
    for (int i = 0; i <= waits; i++) begin
      bus_pins(2, w, m, a, wd);
      ready = (i == waits);                          // R7
      ad_in = (i == waits) ? rd : ~rd;               // R8 capture point
      @(negedge clk);
    end
    bus_pins(4, w, m, a, wd);                        // T4
    ready = $urandom;
    ad_in = DW'($urandom);
    @(negedge clk);
    if (!w) begin
      for (int i = 0; i <= bp; i++) begin
        chk(rsp_valid == 1'b1, "R8 rsp_valid", rsp_valid, 1);
        chk(rsp_rdata == rd, "R8 rsp_rdata", rsp_rdata, rd);
        chk(req_ready == 1'b0, "R1 no accept during rsp", req_ready, 0);
        rsp_ready = (i == bp);
        @(negedge clk);
      end
      rsp_ready = 0;
    end
    chk(rsp_valid == 1'b0, "R8 no rsp after cycle", rsp_valid, 0);
    chk(mio == m, "R4 mio held in idle", mio, m);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    idle_pins();
    chk(lat_addr == '0, "R3 latch reset", lat_addr, 0);

    // directed corners
    run(1'b0, 1'b1, 20'hA5C3E, 16'h0000, 16'h1234, 0, 0);
    run(1'b1, 1'b1, 20'h5F00D, 16'hBEEF, 16'h0000, 0, 0);
    run(1'b0, 1'b0, 20'h000FF, 16'h0000, 16'hC0DE, 5, 3);
    run(1'b1, 1'b0, 20'hFFFFF, 16'h8001, 16'h0000, 4, 0);
    run(1'b0, 1'b1, 20'h00000, 16'h0000, 16'hFFFF, 1, 1);

    // random traffic
    for (int n = 0; n < 60; n++) begin
      int gap;
      run($urandom_range(0, 1), $urandom_range(0, 1), AW'($urandom), DW'($urandom),
          DW'($urandom), $urandom_range(0, 3), $urandom_range(0, 2));
      gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        rsp_ready = $urandom;                        // R8 no effect while idle
        @(negedge clk);
        idle_pins();
      end
      rsp_ready = 0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule